// File: doc/BRIEF.md
# Receive Readout Alignment and Word Countdown Controller

This block stands between a receive data FIFO of 32-bit words and the host that drains it. At the start of each packet it takes the packet length in words. It then passes the packet's words to the host, one word for each read strobe. After the last real word it supplies zero-valued filler words until the words read for that buffer fill a whole alignment unit of 4, 16 or 32 bytes. The host drops the filler.

Alongside the framing, a countdown register that the host loads counts every word handed out. It raises a sticky interrupt at the moment the countdown reaches zero. A discard command in the configuration register sends a one-cycle flush to the receive data and status FIFOs, which empties them and clears their pointers. The same command returns the framing logic to idle.

Configuration register layout, with CNT_W = 12: bits [11:0] hold the countdown value, bit [12] is the discard command, and bits [14:13] hold the alignment code. Any write stores the whole register. The asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `rx_align_ctrl`

## Requirements
- R1: When a packet is read, the data words come out on `host_rdata` in FIFO order. Each accepted read of a data word pulses `fifo_pop` once. `host_valid` goes high one cycle after `fifo_valid` is seen while the block is idle.
- R2: The alignment code selects the padding. Code 0 pads to 1 word (4 bytes), code 1 to 4 words (16 bytes) and code 2 to 8 words (32 bytes). After the last data word, filler words are offered until the number of words read for the packet is a multiple of the selected size. No filler is offered beyond that.
- R3: Filler words read as 0x00000000, keep `host_valid` high, and never pulse `fifo_pop`. The reserved code 3 adds no filler.
- R4: The alignment code is captured when a packet starts. A write of a new code while a packet is partly read leaves that packet's padding unchanged and applies from the next packet. The written code reads back in bits [14:13] of `cfg_rdata`.
- R5: The countdown resets to 0 and is loaded from bits [11:0] by every configuration write. It decreases by one for each accepted host read, filler included. It never goes below zero, and it reads back in bits [11:0] of `cfg_rdata`.
- R6: A write made before the countdown reaches zero replaces the value, and counting continues from the new value.
- R7: `dma_irq` rises in the cycle after a read takes the countdown from 1 to 0. It stays high until `irq_ack` is pulsed. Further reads while the countdown is zero do not raise it again.
- R8: A write with bit [12] set makes `fifo_flush` high for exactly the next cycle. Bit [12] of `cfg_rdata` always reads 0.
- R9: A discard issued in the middle of a packet cancels any pending filler. `host_valid` is low in the flush cycle, framing restarts from idle, and the next packet is padded as if it were the first.
- R10: Out of reset `cfg_rdata` is 0, and `dma_irq`, `host_valid` and `fifo_flush` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 15 | Write data: count [11:0], discard [12], alignment [14:13] |
| cfg_rdata | output | 15 | Readback: countdown, 0, alignment code |
| fifo_valid | input | 1 | Receive data FIFO holds at least one word |
| fifo_rdata | input | 32 | Word at the head of the receive data FIFO |
| pkt_len | input | 12 | Length in words of the packet at the head |
| fifo_pop | output | 1 | Removes the head word from the FIFO |
| fifo_flush | output | 1 | One-cycle flush of the data and status FIFOs |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Word returned to the host |
| host_valid | output | 1 | A word is offered on host_rdata |
| irq_ack | input | 1 | Clears the countdown interrupt |
| dma_irq | output | 1 | Countdown-reached-zero interrupt |

## Verification
The assertions assume three things about the inputs. `pkt_len` is nonzero whenever a packet starts. `fifo_valid` stays high until every data word of the current packet has been popped. The discard command is not written in two consecutive cycles. The bench's FIFO model sets the word count to exactly the packet length and raises `fifo_valid` only after the length is in place. It makes configuration writes in cycles where no host read is pending and spaces them at least one cycle apart. On a flush, the model empties itself by jumping its read index to its write index, as a real FIFO clearing its pointers would.

// File: rtl/rx_align_pkg.sv
package rx_align_pkg;

  localparam int PAD_W = 3;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_DATA = 2'd1,
    FR_PAD  = 2'd2
  } frame_state_e;

  function automatic logic [PAD_W-1:0] align_mask(input logic [1:0] code);
    case (code)
      2'b01:   return PAD_W'(3);
      2'b10:   return PAD_W'(7);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/rx_cfg_regs.sv
module rx_cfg_regs #(
  parameter int CNT_W = 12,
  localparam int CFG_W = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [1:0]       align_q,
  output logic             flush_q,
  output logic             cnt_ld,
  output logic [CNT_W-1:0] cnt_ld_val
);

  logic [1:0] align_d;
  logic       flush_d;

  always_comb begin
    align_d = align_q;
    if (cfg_wr) align_d = cfg_wdata[CNT_W+2:CNT_W+1];
    flush_d = cfg_wr & cfg_wdata[CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_q <= '0;
      flush_q <= 1'b0;
    end else begin
      align_q <= align_d;
      flush_q <= flush_d;
    end
  end

  assign cnt_ld     = cfg_wr;
  assign cnt_ld_val = cfg_wdata[CNT_W-1:0];

  p_flush_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[CNT_W]) |=> flush_q);

  p_flush_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && !$past(cfg_wr && cfg_wdata[CNT_W], 2)) |=> !flush_q);

endmodule

// File: rtl/rx_dma_counter.sv
module rx_dma_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             word_rd,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q
);

  logic [CNT_W-1:0] cnt_d;
  logic             irq_d;
  logic             hit_zero;

  always_comb begin
    cnt_d    = cnt_q;
    hit_zero = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
    end else if (word_rd && (cnt_q != '0)) begin
      cnt_d    = cnt_q - 1'b1;
      hit_zero = (cnt_q == CNT_W'(1));
    end
    irq_d = irq_q;
    if (irq_ack)  irq_d = 1'b0;
    if (hit_zero) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  p_dec_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd && !ld && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_no_dec_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && (cnt_q == '0)) |=> (cnt_q == '0));

  p_irq_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (cnt_q == '0));

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> irq_q);

endmodule

// File: rtl/rx_pad_framer.sv
module rx_pad_framer
  import rx_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        align_cfg,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_rdata,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              host_rd,
  output logic              fifo_pop,
  output logic              host_valid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              word_rd
);

  frame_state_e     state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [PAD_W-1:0] pos_q, pos_d;
  logic [PAD_W-1:0] pad_q, pad_d;
  logic [PAD_W-1:0] mask_q, mask_d;
  logic [PAD_W-1:0] fill_need;

  assign fill_need = (~pos_q) & mask_q;

  always_comb begin
    state_d    = state_q;
    rem_d      = rem_q;
    pos_d      = pos_q;
    pad_d      = pad_q;
    mask_d     = mask_q;
    host_valid = 1'b0;
    fifo_pop   = 1'b0;
    unique case (state_q)
      FR_IDLE: begin
        if (fifo_valid) begin
          rem_d   = pkt_len;
          pos_d   = '0;
          mask_d  = align_mask(align_cfg);
          state_d = FR_DATA;
        end
      end
      FR_DATA: begin
        host_valid = fifo_valid;
        if (host_rd && fifo_valid) begin
          fifo_pop = 1'b1;
          pos_d    = pos_q + 1'b1;
          rem_d    = rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) begin
            pad_d   = fill_need;
            state_d = (fill_need == '0) ? FR_IDLE : FR_PAD;
          end
        end
      end
      FR_PAD: begin
        host_valid = 1'b1;
        if (host_rd) begin
          pad_d = pad_q - 1'b1;
          if (pad_q == PAD_W'(1)) state_d = FR_IDLE;
        end
      end
      default: state_d = FR_IDLE;
    endcase
    if (flush) begin
      state_d    = FR_IDLE;
      pad_d      = '0;
      host_valid = 1'b0;
      fifo_pop   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      rem_q   <= '0;
      pos_q   <= '0;
      pad_q   <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      pos_q   <= pos_d;
      pad_q   <= pad_d;
      mask_q  <= mask_d;
    end
  end

  assign word_rd    = host_rd & host_valid;
  assign host_rdata = (state_q == FR_DATA) ? fifo_rdata : '0;

  p_len_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_IDLE && fifo_valid && !flush) |-> (pkt_len != '0));

  p_align_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != FR_IDLE) |=> $stable(mask_q));

  p_flush_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (state_q == FR_IDLE));

  p_pad_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_PAD) |-> ((pad_q != '0) && (pad_q <= mask_q)));

endmodule

// File: rtl/rx_align_ctrl.sv
module rx_align_ctrl #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int LEN_W  = 12,
  localparam int CFG_W = CNT_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_rdata,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              fifo_pop,
  output logic              fifo_flush,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_valid,
  input  logic              irq_ack,
  output logic              dma_irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [1:0]       align_q;
  logic             flush_q;
  logic             cnt_ld;
  logic [CNT_W-1:0] cnt_ld_val;
  logic [CNT_W-1:0] cnt_q;
  logic             word_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  rx_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .align_q    (align_q),
    .flush_q    (flush_q),
    .cnt_ld     (cnt_ld),
    .cnt_ld_val (cnt_ld_val)
  );

  rx_pad_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flush      (flush_q),
    .align_cfg  (align_q),
    .fifo_valid (fifo_valid),
    .fifo_rdata (fifo_rdata),
    .pkt_len    (pkt_len),
    .host_rd    (host_rd),
    .fifo_pop   (fifo_pop),
    .host_valid (host_valid),
    .host_rdata (host_rdata),
    .word_rd    (word_rd)
  );

  rx_dma_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld      (cnt_ld),
    .ld_val  (cnt_ld_val),
    .word_rd (word_rd),
    .irq_ack (irq_ack),
    .cnt_q   (cnt_q),
    .irq_q   (dma_irq)
  );

  assign fifo_flush = flush_q;
  assign cfg_rdata  = {align_q, 1'b0, cnt_q};

endmodule

// File: tb/rx_align_ctrl_bench.sv
module rx_align_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int V_LEN [NV] = '{1, 3, 4, 5, 8, 2, 9, 6};
  localparam int V_AL  [NV] = '{0, 1, 1, 2, 2, 3, 2, 1};
  localparam int V_PAD [NV] = '{0, 1, 0, 3, 0, 0, 7, 2};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [14:0] cfg_wdata;
  logic [14:0] cfg_rdata;
  logic        fifo_valid;
  logic [31:0] fifo_rdata;
  logic [11:0] pkt_len;
  logic        fifo_pop;
  logic        fifo_flush;
  logic        host_rd;
  logic [31:0] host_rdata;
  logic        host_valid;
  logic        irq_ack;
  logic        dma_irq;

  logic [23:0] widx;
  logic [23:0] wend;
  logic [23:0] exp_idx;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_align_ctrl u_rx_align_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .fifo_valid(fifo_valid), .fifo_rdata(fifo_rdata),
    .pkt_len(pkt_len), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_valid(host_valid),
    .irq_ack(irq_ack), .dma_irq(dma_irq)
  );

  // FIFO model: read index advances on pop, jumps to the write index on flush
  always_ff @(posedge clk) begin
    if (!rst_n)          widx <= '0;
    else if (fifo_flush) widx <= wend;
    else if (fifo_pop)   widx <= widx + 1'b1;
  end
  assign fifo_valid = (widx != wend);
  assign fifo_rdata = {8'hA5, widx};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [1:0] al, input logic disc, input logic [11:0] cnt);
    cfg_wdata = {al, disc, cnt};
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic start_pkt(input int len);
    int waited;
    pkt_len = 12'(len);
    wend = widx + 24'(len);
    waited = 0;
    while (!host_valid && waited < 8) begin
      @(negedge clk);
      waited++;
    end
    check("R1 host_valid at packet start", 32'(host_valid), 32'd1);
  endtask

  task automatic read_data(input string req);
    check(req, 32'(host_valid), 32'd1);
    check(req, host_rdata, {8'hA5, exp_idx});
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    exp_idx = exp_idx + 1'b1;
  endtask

  task automatic read_pad(input string req);
    check(req, 32'(host_valid), 32'd1);
    check(req, host_rdata, 32'h0);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic ack_irq();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; pkt_len = '0;
    host_rd = 1'b0; irq_ack = 1'b0; wend = '0; exp_idx = '0;
    repeat (3) @(negedge clk);
    check("R10 cfg_rdata in reset", 32'(cfg_rdata), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 cfg_rdata", 32'(cfg_rdata), 32'h0);
    check("R10 dma_irq", 32'(dma_irq), 32'd0);
    check("R10 host_valid", 32'(host_valid), 32'd0);
    check("R10 fifo_flush", 32'(fifo_flush), 32'd0);

    // Table walk: length, alignment code, expected filler count (R1 R2 R3 R5 R7)
    for (int i = 0; i < NV; i++) begin
      ack_irq();
      cfg_write(2'(V_AL[i]), 1'b0, 12'(V_LEN[i] + V_PAD[i]));
      start_pkt(V_LEN[i]);
      for (int j = 0; j < V_LEN[i]; j++) read_data("R1 data word");
      for (int j = 0; j < V_PAD[i]; j++) read_pad("R3 filler word");
      check("R2 no extra filler", 32'(host_valid), 32'd0);
      check("R5 countdown at zero", 32'(cfg_rdata[11:0]), 32'd0);
      check("R7 irq raised", 32'(dma_irq), 32'd1);
    end
    ack_irq();
    check("R7 irq cleared by ack", 32'(dma_irq), 32'd0);

    // R4: alignment change mid-packet applies to the next packet
    cfg_write(2'd2, 1'b0, 12'd100);
    start_pkt(3);
    read_data("R4 data");
    cfg_write(2'd0, 1'b0, 12'd100);
    check("R4 new code reads back", 32'(cfg_rdata[14:13]), 32'd0);
    read_data("R4 data");
    read_data("R4 data");
    for (int j = 0; j < 5; j++) read_pad("R4 old code filler");
    check("R4 packet ends after old padding", 32'(host_valid), 32'd0);
    start_pkt(3);
    for (int j = 0; j < 3; j++) read_data("R4 next packet data");
    check("R4 next packet uses new code", 32'(host_valid), 32'd0);

    // R6 / R7: overwrite, sticky irq, no re-assertion at zero
    cfg_write(2'd0, 1'b0, 12'd10);
    start_pkt(12);
    read_data("R6 data");
    read_data("R6 data");
    check("R5 countdown after two reads", 32'(cfg_rdata[11:0]), 32'd8);
    cfg_write(2'd0, 1'b0, 12'd3);
    check("R6 overwritten value", 32'(cfg_rdata[11:0]), 32'd3);
    read_data("R6 data");
    read_data("R6 data");
    check("R6 countdown continues", 32'(cfg_rdata[11:0]), 32'd1);
    check("R7 irq not yet", 32'(dma_irq), 32'd0);
    read_data("R6 data");
    check("R6 irq after new value expires", 32'(dma_irq), 32'd1);
    repeat (3) @(negedge clk);
    check("R7 irq held", 32'(dma_irq), 32'd1);
    ack_irq();
    check("R7 irq acked", 32'(dma_irq), 32'd0);
    for (int j = 0; j < 7; j++) read_data("R7 data at zero");
    check("R7 no re-assertion at zero", 32'(dma_irq), 32'd0);
    check("R5 countdown stays zero", 32'(cfg_rdata[11:0]), 32'd0);

    // R8 / R9: discard during filler
    cfg_write(2'd2, 1'b0, 12'd0);
    start_pkt(2);
    read_data("R9 data");
    read_data("R9 data");
    check("R9 filler pending", 32'(host_valid), 32'd1);
    cfg_write(2'd2, 1'b1, 12'd0);
    check("R8 flush pulse", 32'(fifo_flush), 32'd1);
    check("R8 discard reads 0", 32'(cfg_rdata[12]), 32'd0);
    check("R9 no word during flush", 32'(host_valid), 32'd0);
    @(negedge clk);
    check("R8 flush one cycle", 32'(fifo_flush), 32'd0);
    check("R9 filler cancelled", 32'(host_valid), 32'd0);
    start_pkt(3);
    for (int j = 0; j < 3; j++) read_data("R9 restart data");
    for (int j = 0; j < 5; j++) read_pad("R9 restart filler");
    check("R9 restart padding complete", 32'(host_valid), 32'd0);

    // R8: discard while data words remain in the FIFO
    start_pkt(4);
    read_data("R8 data");
    cfg_write(2'd0, 1'b1, 12'd0);
    check("R8 flush pulse mid data", 32'(fifo_flush), 32'd1);
    @(negedge clk);
    check("R8 FIFO emptied", 32'(fifo_valid), 32'd0);
    check("R9 idle after flush", 32'(host_valid), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule